// File: doc/BRIEF.md
# Branch Target Address Generator

This unit works out the next program counter of a small 8-bit processor core. Each cycle it receives the address of the instruction that follows the current one, the address fields the decoder pulled out of the instruction, the accumulator, the data pointer and a condition flag. Once a condition has been resolved upstream, the unit picks the target and registers it as the new program counter.

The unit handles six target kinds:

- **Sequential flow.** The program counter moves to the next instruction.
- **Signed short hop.** An 8-bit displacement is measured from the next instruction.
- **In-page jump.** An 11-bit field replaces the low address bits. The field is built from the top three bits of the opcode byte and the full second byte.
- **Full 16-bit jump.**
- **Table jump.** The target is the data pointer plus the accumulator.
- **Conditional short hop.** It is taken or not taken according to a flag that was evaluated elsewhere.

Fetch, decode and condition evaluation sit outside the unit. The registered output changes only on cycles with the step enable raised.

Top module: `branch_target_gen`

## Requirements
- R1: While `rst_n` is low, `next_pc` is 0000h, with the reset taking effect without waiting for a clock edge. After release, `next_pc` stays 0000h until the first enabled update.
- R2: On a rising edge with `step_en` low, `next_pc` keeps its value whatever the other inputs carry.
- R3: The `kind` code 0 selects sequential flow: `next_pc` becomes `seq_pc`.
- R4: The `kind` code 1 selects the short hop. The target is `seq_pc` plus `rel_off` sign-extended to 16 bits, so the reach is -128 to +127. Any carry out of bit 15 is dropped: seq 0015h with FEh gives 0013h, and seq FFF0h with 20h gives 0010h.
- R5: The `kind` code 3 selects the full jump: `next_pc` becomes `long_fld`.
- R6: The `kind` code 2 selects the in-page jump. The target is {`seq_pc`[15:11], `abs_hi`[2:0], `abs_lo`[7:0]}, where `abs_hi` carries bits 7:5 of the opcode byte.
- R7: The 2K page of an in-page jump is taken from `seq_pc`, the address after the branch, so a branch ending at a page boundary lands in the following page.
- R8: The `kind` code 4 selects the table jump. The target is `dptr` plus `acc` zero-extended, modulo 2^16.
- R9: The `kind` code 5 selects the conditional short hop. With `cond_met` high the target is computed as in R4; with `cond_met` low it is `seq_pc`.
- R10: The unused `kind` codes 6 and 7 behave as sequential flow.
- R11: A target selected with `step_en` high appears on `next_pc` after the next rising edge, not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the unit |
| step_en | input | 1 | Load the selected target on this edge |
| kind | input | 3 | Target kind code (see R3 to R10) |
| seq_pc | input | 16 | Address of the next sequential instruction |
| rel_off | input | 8 | Signed short displacement |
| abs_hi | input | 3 | Bits 7:5 of the in-page jump opcode byte |
| abs_lo | input | 8 | Second byte of the in-page jump |
| long_fld | input | 16 | Full 16-bit target |
| acc | input | 8 | Accumulator value |
| dptr | input | 16 | Data pointer value |
| cond_met | input | 1 | Resolved branch condition |
| next_pc | output | 16 | Registered next program counter |

## Verification
The checker watches four things on every cycle:

- that `next_pc` holds while the step enable is low;
- that a full jump loads the field;
- that an in-page jump keeps the five page bits of the sequential address;
- that sequential flow, not-taken conditionals and unused codes all return the sequential address.

Some behaviours show only in the bench's scenarios, because they depend on chosen operand values:

- the arithmetic of the signed hop, with its wrap across zero and across FFFFh;
- the table-jump carry and wrap;
- the page-boundary case;
- the asynchronous reset value;
- the one-edge latency.

// File: rtl/branch_target_pkg.sv
package branch_target_pkg;

  typedef enum logic [2:0] {
    K_SEQ   = 3'd0,
    K_SHORT = 3'd1,
    K_PAGE  = 3'd2,
    K_LONG  = 3'd3,
    K_INDEX = 3'd4,
    K_COND  = 3'd5
  } bt_kind_e;

endpackage

// File: rtl/pc_rel_adder.sv
module pc_rel_adder #(
  parameter int PC_W  = 16,
  parameter int OFF_W = 8
) (
  input  logic [PC_W-1:0]  base,
  input  logic [OFF_W-1:0] off,
  output logic [PC_W-1:0]  target
);
  localparam int EXT_W = PC_W - OFF_W;

  logic [PC_W-1:0] off_ext;

  // Sign-extend the displacement; the sum is truncated to PC_W bits.
  always_comb begin
    off_ext = {{EXT_W{off[OFF_W-1]}}, off};
    target  = base + off_ext;
  end
endmodule

// File: rtl/pc_page_splice.sv
module pc_page_splice #(
  parameter int PC_W   = 16,
  parameter int PAGE_W = 11,
  parameter int BYTE_W = 8
) (
  input  logic [PC_W-1:0]          base,
  input  logic [PAGE_W-BYTE_W-1:0] hi_bits,
  input  logic [BYTE_W-1:0]        lo_byte,
  output logic [PC_W-1:0]          target
);
  // Page number comes from the sequential address; offset from the fields.
  always_comb begin
    target = {base[PC_W-1:PAGE_W], hi_bits, lo_byte};
  end
endmodule

// File: rtl/pc_index_adder.sv
module pc_index_adder #(
  parameter int PC_W  = 16,
  parameter int ACC_W = 8
) (
  input  logic [PC_W-1:0]  ptr,
  input  logic [ACC_W-1:0] idx,
  output logic [PC_W-1:0]  target
);
  localparam int PAD_W = PC_W - ACC_W;

  always_comb begin
    target = ptr + {{PAD_W{1'b0}}, idx};
  end
endmodule

// File: rtl/branch_target_gen.sv
module branch_target_gen
  import branch_target_pkg::*;
#(
  parameter int PC_W        = 16,
  parameter int OFF_W       = 8,
  parameter int PAGE_W      = 11,
  parameter int BYTE_W      = 8,
  parameter int ACC_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      step_en,
  input  logic [2:0]                kind,
  input  logic [PC_W-1:0]           seq_pc,
  input  logic [OFF_W-1:0]          rel_off,
  input  logic [PAGE_W-BYTE_W-1:0]  abs_hi,
  input  logic [BYTE_W-1:0]         abs_lo,
  input  logic [PC_W-1:0]           long_fld,
  input  logic [ACC_W-1:0]          acc,
  input  logic [PC_W-1:0]           dptr,
  input  logic                      cond_met,
  output logic [PC_W-1:0]           next_pc
);
  localparam int HI_W = PAGE_W - BYTE_W;

  // Reset synchroniser: asserts at once, releases on the clock.
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rst_q_n;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[gi] <= 1'b0;
          else        sync_q[gi] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[gi] <= 1'b0;
          else        sync_q[gi] <= sync_q[gi-1];
        end
      end
    end
  endgenerate

  assign rst_q_n = sync_q[SYNC_STAGES-1];

  // Candidate targets from the three datapath units
  logic [PC_W-1:0] rel_tgt;
  logic [PC_W-1:0] page_tgt;
  logic [PC_W-1:0] idx_tgt;

  pc_rel_adder #(
    .PC_W  (PC_W),
    .OFF_W (OFF_W)
  ) u_rel (
    .base   (seq_pc),
    .off    (rel_off),
    .target (rel_tgt)
  );

  pc_page_splice #(
    .PC_W   (PC_W),
    .PAGE_W (PAGE_W),
    .BYTE_W (BYTE_W)
  ) u_page (
    .base    (seq_pc),
    .hi_bits (abs_hi[HI_W-1:0]),
    .lo_byte (abs_lo),
    .target  (page_tgt)
  );

  pc_index_adder #(
    .PC_W  (PC_W),
    .ACC_W (ACC_W)
  ) u_idx (
    .ptr    (dptr),
    .idx    (acc),
    .target (idx_tgt)
  );

  // Next-state selection
  logic [PC_W-1:0] pc_d;

  always_comb begin
    case (kind)
      K_SHORT: pc_d = rel_tgt;
      K_PAGE:  pc_d = page_tgt;
      K_LONG:  pc_d = long_fld;
      K_INDEX: pc_d = idx_tgt;
      K_COND:  pc_d = cond_met ? rel_tgt : seq_pc;
      default: pc_d = seq_pc;
    endcase
  end

  // Program counter register with explicit clock enable
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)     next_pc <= '0;
    else if (step_en) next_pc <= pc_d;
  end
endmodule

// File: rtl/branch_target_gen_chk.sv
module branch_target_gen_chk #(
  parameter int PC_W   = 16,
  parameter int PAGE_W = 11
) (
  input logic            clk,
  input logic            rst_q_n,
  input logic            step_en,
  input logic [2:0]      kind,
  input logic [PC_W-1:0] seq_pc,
  input logic [PC_W-1:0] long_fld,
  input logic            cond_met,
  input logic [PC_W-1:0] next_pc
);
  // R2: no enable, no change
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    !step_en |=> $stable(next_pc));

  // R3: sequential flow
  p_seq_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (step_en && kind == 3'd0) |=> next_pc == $past(seq_pc));

  // R5: full jump
  p_long_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (step_en && kind == 3'd3) |=> next_pc == $past(long_fld));

  // R6/R7: in-page jump keeps the page of the sequential address
  p_page_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (step_en && kind == 3'd2) |=>
      next_pc[PC_W-1:PAGE_W] == $past(seq_pc[PC_W-1:PAGE_W]));

  // R9: conditional not taken falls through
  p_fall_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (step_en && kind == 3'd5 && !cond_met) |=> next_pc == $past(seq_pc));

  // R10: unused codes fall through
  p_unused_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (step_en && kind > 3'd5) |=> next_pc == $past(seq_pc));
endmodule

bind branch_target_gen branch_target_gen_chk #(
  .PC_W   (PC_W),
  .PAGE_W (PAGE_W)
) chk_i (
  .clk      (clk),
  .rst_q_n  (rst_q_n),
  .step_en  (step_en),
  .kind     (kind),
  .seq_pc   (seq_pc),
  .long_fld (long_fld),
  .cond_met (cond_met),
  .next_pc  (next_pc)
);

// File: tb/branch_target_gen_tb_top.sv
module branch_target_gen_tb_top;
  logic        clk;
  logic        rst_n;
  logic        step_en;
  logic [2:0]  kind;
  logic [15:0] seq_pc;
  logic [7:0]  rel_off;
  logic [2:0]  abs_hi;
  logic [7:0]  abs_lo;
  logic [15:0] long_fld;
  logic [7:0]  acc;
  logic [15:0] dptr;
  logic        cond_met;
  logic [15:0] next_pc;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  branch_target_gen dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_en  (step_en),
    .kind     (kind),
    .seq_pc   (seq_pc),
    .rel_off  (rel_off),
    .abs_hi   (abs_hi),
    .abs_lo   (abs_lo),
    .long_fld (long_fld),
    .acc      (acc),
    .dptr     (dptr),
    .cond_met (cond_met),
    .next_pc  (next_pc)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Vector fields: kind(3) seq(16) rel(8) hi(3) lo(8) long(16) acc(8) dptr(16) cond(1) exp(16)
  localparam int NV = 15;
  localparam logic [94:0] VEC [NV] = '{
    {3'd0, 16'h1234, 8'h00, 3'd0, 8'h00, 16'h0000, 8'h00, 16'h0000, 1'b0, 16'h1234}, // R3
    {3'd1, 16'h0100, 8'h7F, 3'd0, 8'h00, 16'h0000, 8'h00, 16'h0000, 1'b0, 16'h017F}, // R4 fwd max
    {3'd1, 16'h0015, 8'hFE, 3'd0, 8'h00, 16'h0000, 8'h00, 16'h0000, 1'b0, 16'h0013}, // R4 back
    {3'd1, 16'h0001, 8'h80, 3'd0, 8'h00, 16'h0000, 8'h00, 16'h0000, 1'b0, 16'hFF81}, // R4 wrap low
    {3'd1, 16'hFFF0, 8'h20, 3'd0, 8'h00, 16'h0000, 8'h00, 16'h0000, 1'b0, 16'h0010}, // R4 wrap high
    {3'd3, 16'h0000, 8'h00, 3'd0, 8'h00, 16'hBEEF, 8'h00, 16'h0000, 1'b0, 16'hBEEF}, // R5
    {3'd2, 16'h4A21, 8'h00, 3'd7, 8'h5C, 16'h0000, 8'h00, 16'h0000, 1'b0, 16'h4F5C}, // R6
    {3'd2, 16'h0800, 8'h00, 3'd0, 8'h10, 16'h0000, 8'h00, 16'h0000, 1'b0, 16'h0810}, // R7
    {3'd2, 16'hFFFF, 8'h00, 3'd5, 8'h00, 16'h0000, 8'h00, 16'h0000, 1'b0, 16'hFD00}, // R6 top page
    {3'd4, 16'h0000, 8'h00, 3'd0, 8'h00, 16'h0000, 8'hFF, 16'h1F01, 1'b0, 16'h2000}, // R8 carry
    {3'd4, 16'h0000, 8'h00, 3'd0, 8'h00, 16'h0000, 8'h10, 16'hFFF8, 1'b0, 16'h0008}, // R8 wrap
    {3'd5, 16'h0200, 8'hF0, 3'd0, 8'h00, 16'h0000, 8'h00, 16'h0000, 1'b1, 16'h01F0}, // R9 taken
    {3'd5, 16'h0200, 8'hF0, 3'd0, 8'h00, 16'h0000, 8'h00, 16'h0000, 1'b0, 16'h0200}, // R9 not taken
    {3'd6, 16'h3333, 8'h12, 3'd1, 8'h22, 16'hAAAA, 8'h01, 16'h5555, 1'b1, 16'h3333}, // R10
    {3'd7, 16'h4444, 8'h12, 3'd1, 8'h22, 16'hAAAA, 8'h01, 16'h5555, 1'b1, 16'h4444}  // R10
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: next_pc=%h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic drive(input logic [94:0] v);
    kind     = v[94:92];
    seq_pc   = v[91:76];
    rel_off  = v[75:68];
    abs_hi   = v[67:65];
    abs_lo   = v[64:57];
    long_fld = v[56:41];
    acc      = v[40:33];
    dptr     = v[32:17];
    cond_met = v[16];
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    step_en = 1'b0;
    drive('0);
    repeat (3) @(negedge clk);
    check("R1 during reset", next_pc, 16'h0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", next_pc, 16'h0000);

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      step_en = 1'b1;
      @(negedge clk);
      check($sformatf("vector %0d (R3-R10 table)", i), next_pc, VEC[i][15:0]);
    end

    // R2: hold with enable low while inputs change
    step_en = 1'b0;
    drive(VEC[5]);
    @(negedge clk);
    check("R2 hold", next_pc, 16'h4444);
    drive(VEC[9]);
    @(negedge clk);
    check("R2 hold second edge", next_pc, 16'h4444);

    // R11: result visible only after the edge
    drive(VEC[5]);
    step_en = 1'b1;
    #2;
    check("R11 before edge", next_pc, 16'h4444);
    @(negedge clk);
    check("R11 after edge", next_pc, 16'hBEEF);

    // R1: asynchronous reset mid-run
    rst_n = 1'b0;
    #1;
    check("R1 async assert", next_pc, 16'h0000);
    @(negedge clk);
    step_en = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 held after re-release", next_pc, 16'h0000);

    // R7: branch ending just before a page boundary, taking the new page
    drive({3'd2, 16'h1000, 8'h00, 3'd2, 8'hAB, 16'h0000, 8'h00, 16'h0000, 1'b0, 16'h0000});
    step_en = 1'b1;
    @(negedge clk);
    check("R7 page of seq_pc", next_pc, 16'h12AB);

    finish_run();
  end
endmodule